// File: doc/BRIEF.md
# SPI Byte-Addressed Nonvolatile Memory Target

This block acts as the target side of a four-wire SPI link and models a serial memory whose writes complete at once. A host lowers chip select, shifts in an 8-bit command, then a start address most significant bit first, and then streams data bytes. Each byte read or written moves an internal address pointer forward by one. The pointer rolls over to zero at the top of the array. There is no page buffer and no busy period: every received byte lands in the array as soon as its last bit is sampled.

Writes are guarded by a write-enable latch. A short framed command arms the latch, and the latch drops again when a memory-write or status-write frame closes. A one-byte status word reports the latch and holds three host-writable protection bits, which are kept here for a protection unit nearby.

The block runs wholly in a fast system clock domain. Chip select, SCK and the serial input are synchronised and SCK edges are found by comparison, so a single clock drives every register. The serial output is tri-stated, and a separate enable pin reports when it is driven.

Top module: `spi_nvmem_target`

## Requirements
- R1: Command codes are 0x06 (arm latch), 0x04 (disarm latch), 0x05 (status read), 0x01 (status write), 0x03 (memory read) and 0x02 (memory write). Only the first byte of a frame is decoded as a command; a later byte that matches a command code has no command effect.
- R2: Input bits are captured on rising SCK and output bits change on falling SCK, and transfers are correct whether SCK idles low (mode 0) or high (mode 3) when chip select falls.
- R3: After a memory command, ADDR_BYTES address bytes follow MSB first, and the first data byte comes right after the last address byte.
- R4: With ADDR_BYTES = 1, bit 3 of the command byte is address bit 8, so 0x0B reads and 0x0A writes the upper 256 bytes, while 0x03 and 0x02 reach the lower 256.
- R5: Within one frame the address advances by one after each data byte and wraps from 2^MEM_AW-1 to 0, for both reads and writes.
- R6: A write data byte is stored on the eighth rising SCK edge of that byte; a frame that ends partway through a byte leaves the array unchanged for that byte.
- R7: The status byte is {bit7 protect-enable, bits6:4 zero, bits3:2 block bits, bit1 latch, bit0 zero}. Command 0x06 sets the latch, 0x04 clears it, the chip-select rise that closes a 0x02 or 0x01 frame clears it, and a status read leaves it unchanged. A status write with the latch set loads bits 7, 3 and 2.
- R8: A memory write or status write issued while the latch is clear changes neither the array nor the status byte.
- R9: The serial output enable is low whenever chip select is high, and a read in progress stops driving at the instant chip select rises.
- R10: An unrecognised command byte is ignored for the rest of the frame: the output stays undriven and no state changes.
- R11: After reset the output is undriven, the latch is clear and the status byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all SPI pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host, high impedance when not driven |
| soOe | output | 1 | High while `so` is driven |

## Verification
The bench builds two copies: one with a two-byte address over a 2048-byte array, and one with a one-byte address over a 512-byte array. The wider copy reaches the latch sequencing, the status-word bits, pointer rollover at 0x7FF, partial-byte frames, both SCK idle levels and a read cut off by chip select. The narrow copy is the only one where command bit 3 acts as an address bit, so it carries the upper-half and lower-half access checks.

// File: rtl/spi_nvmem_pkg.sv
package spi_nvmem_pkg;

  localparam logic [7:0] OP_ARM    = 8'h06;
  localparam logic [7:0] OP_DISARM = 8'h04;
  localparam logic [7:0] OP_STRD   = 8'h05;
  localparam logic [7:0] OP_STWR   = 8'h01;
  localparam logic [7:0] OP_MEMRD  = 8'h03;
  localparam logic [7:0] OP_MEMWR  = 8'h02;

  // Strobes from the sequencer to the datapath, one clock wide each.
  typedef struct packed {
    logic addrInit;   // clear pointer, seed with hiBit
    logic hiBit;      // address bit carried in the command byte
    logic addrShift;  // shift a received address byte into the pointer
    logic fetchMem;   // load the next array byte into the output shifter
    logic fetchStat;  // load the status byte into the output shifter
    logic memWrite;   // store the received byte at the pointer
    logic statWrite;  // load the protection bits from the received byte
    logic welSet;
    logic welClr;
    logic txShift;    // falling SCK: present the next output bit
    logic txOff;      // frame closed: stop driving
  } nvStrobe_t;

endpackage

// File: rtl/spi_nvmem_sync.sv
module spi_nvmem_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= dIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/spi_nvmem_ctrl.sv
module spi_nvmem_ctrl
  import spi_nvmem_pkg::*;
#(
  parameter int ADDR_BYTES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sckS,
  input  logic       siS,
  output nvStrobe_t  ctl,
  output logic [7:0] rxByte
);

  localparam logic [7:0] OP_MASK   = (ADDR_BYTES == 1) ? 8'hF7 : 8'hFF;
  localparam logic [1:0] LAST_LEFT = 2'(ADDR_BYTES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_ADDR, S_RDATA, S_WDATA, S_SRD, S_SWR, S_SKIP
  } seqState_t;

  seqState_t  state, nState;
  logic [2:0] bitCnt, nBit;
  logic [6:0] rxSh, nRx;
  logic [1:0] addrLeft, nLeft;
  logic       isRead, nIsRead;
  logic       clrOnEnd, nClr;
  logic       sckD;
  logic       sckRise, sckFall;
  logic [7:0] opMasked;

  assign sckRise  = sckS & ~sckD;
  assign sckFall  = ~sckS & sckD;
  assign rxByte   = {rxSh, siS};
  assign opMasked = rxByte & OP_MASK;

  always_comb begin
    nState  = state;
    nBit    = bitCnt;
    nRx     = rxSh;
    nLeft   = addrLeft;
    nIsRead = isRead;
    nClr    = clrOnEnd;
    ctl     = '0;

    if (csS) begin
      if (state != S_IDLE) begin
        ctl.txOff = 1'b1;
        ctl.welClr = clrOnEnd;
      end
      nState = S_IDLE;
      nClr   = 1'b0;
    end else if (state == S_IDLE) begin
      nState = S_OPC;
      nBit   = '0;
    end else begin
      if (sckFall && (state == S_RDATA || state == S_SRD)) ctl.txShift = 1'b1;
      if (sckRise) begin
        nBit = bitCnt + 3'd1;
        nRx  = rxByte[6:0];
        if (bitCnt == 3'd7) begin
          case (state)
            S_OPC: begin
              if (rxByte == OP_ARM) begin
                ctl.welSet = 1'b1;
                nState = S_SKIP;
              end else if (rxByte == OP_DISARM) begin
                ctl.welClr = 1'b1;
                nState = S_SKIP;
              end else if (rxByte == OP_STRD) begin
                ctl.fetchStat = 1'b1;
                nState = S_SRD;
              end else if (rxByte == OP_STWR) begin
                nClr   = 1'b1;
                nState = S_SWR;
              end else if (opMasked == OP_MEMRD || opMasked == OP_MEMWR) begin
                ctl.addrInit = 1'b1;
                ctl.hiBit    = (ADDR_BYTES == 1) & rxByte[3];
                nIsRead      = (opMasked == OP_MEMRD);
                nClr         = (opMasked == OP_MEMWR);
                nLeft        = LAST_LEFT;
                nState       = S_ADDR;
              end else begin
                nState = S_SKIP;
              end
            end
            S_ADDR: begin
              ctl.addrShift = 1'b1;
              if (addrLeft == 2'd0) begin
                if (isRead) begin
                  ctl.fetchMem = 1'b1;
                  nState = S_RDATA;
                end else begin
                  nState = S_WDATA;
                end
              end else begin
                nLeft = addrLeft - 2'd1;
              end
            end
            S_RDATA: ctl.fetchMem  = 1'b1;
            S_WDATA: ctl.memWrite  = 1'b1;
            S_SRD:   ctl.fetchStat = 1'b1;
            S_SWR: begin
              ctl.statWrite = 1'b1;
              nState = S_SKIP;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      rxSh     <= '0;
      addrLeft <= '0;
      isRead   <= 1'b0;
      clrOnEnd <= 1'b0;
      sckD     <= 1'b0;
    end else begin
      state    <= nState;
      bitCnt   <= nBit;
      rxSh     <= nRx;
      addrLeft <= nLeft;
      isRead   <= nIsRead;
      clrOnEnd <= nClr;
      sckD     <= sckS;
    end
  end

endmodule

// File: rtl/spi_nvmem_dp.sv
module spi_nvmem_dp
  import spi_nvmem_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  nvStrobe_t         ctl,
  input  logic [7:0]        rxByte,
  output logic              soBit,
  output logic              soOe,
  output logic              welQ,
  output logic [MEM_AW-1:0] addrQ,
  output logic [7:0]        statQ
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] mem [DEPTH];
  logic [7:0] txSh;
  logic       fetchPend;
  logic       txLive;
  logic       wpEn;
  logic [1:0] bpBits;
  logic       doWrite;

  assign doWrite = ctl.memWrite & welQ;
  assign statQ   = {wpEn, 3'b000, bpBits, welQ, 1'b0};
  // Raw chip select gates the driver so output stops without sync delay.
  assign soOe    = txLive & ~csN;

  always_ff @(posedge clk) begin
    if (doWrite) mem[addrQ] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      txSh      <= '0;
      soBit     <= 1'b0;
      fetchPend <= 1'b0;
      txLive    <= 1'b0;
      welQ      <= 1'b0;
      wpEn      <= 1'b0;
      bpBits    <= '0;
    end else begin
      fetchPend <= ctl.fetchMem;

      if (ctl.addrInit)       addrQ <= MEM_AW'(ctl.hiBit);
      else if (ctl.addrShift) addrQ <= MEM_AW'({addrQ, rxByte});
      else if (doWrite)       addrQ <= addrQ + 1'b1;
      else if (fetchPend)     addrQ <= addrQ + 1'b1;

      if (fetchPend)          txSh <= mem[addrQ];
      else if (ctl.fetchStat) txSh <= statQ;
      else if (ctl.txShift)   txSh <= {txSh[6:0], 1'b0};

      if (ctl.txShift) begin
        soBit  <= txSh[7];
        txLive <= 1'b1;
      end else if (ctl.txOff) begin
        txLive <= 1'b0;
      end

      if (ctl.welSet)      welQ <= 1'b1;
      else if (ctl.welClr) welQ <= 1'b0;

      if (ctl.statWrite && welQ) begin
        wpEn   <= rxByte[7];
        bpBits <= rxByte[3:2];
      end
    end
  end

endmodule

// File: rtl/spi_nvmem_target.sv
module spi_nvmem_target
  import spi_nvmem_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int MEM_AW     = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  output wire  so,
  output logic soOe
);

  logic              csS, sckS, siS;
  nvStrobe_t         ctl;
  logic [7:0]        rxByte;
  logic              soBit;
  logic              welQ;
  logic [MEM_AW-1:0] addrQ;
  logic [7:0]        statQ;

  spi_nvmem_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({csN, sck, si}),
    .dOut ({csS, sckS, siS})
  );

  spi_nvmem_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csS    (csS),
    .sckS   (sckS),
    .siS    (siS),
    .ctl    (ctl),
    .rxByte (rxByte)
  );

  spi_nvmem_dp #(.MEM_AW(MEM_AW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .ctl    (ctl),
    .rxByte (rxByte),
    .soBit  (soBit),
    .soOe   (soOe),
    .welQ   (welQ),
    .addrQ  (addrQ),
    .statQ  (statQ)
  );

  assign so = soOe ? soBit : 1'bz;

endmodule

// File: rtl/spi_nvmem_chk.sv
module spi_nvmem_chk
  import spi_nvmem_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              soOe,
  input nvStrobe_t         ctl,
  input logic              welQ,
  input logic [MEM_AW-1:0] addrQ,
  input logic [7:0]        statQ
);

  // R9: never drive while deselected
  a_r9_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !soOe);

  // R7: arming takes effect on the next cycle
  a_r7_latch_arms: assert property (@(posedge clk) disable iff (!rstN)
    ctl.welSet |=> welQ);

  // R7: clearing strobe drops the latch
  a_r7_latch_drops: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.welClr && !ctl.welSet) |=> !welQ);

  // R5: a committed write steps the pointer by one, modulo the array size
  a_r5_pointer_steps: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memWrite && welQ) |=> (addrQ == MEM_AW'($past(addrQ) + 1'b1)));

  // R8: status write without the latch leaves the status byte alone
  a_r8_status_locked: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.statWrite && !welQ) |=> (statQ == $past(statQ)));

  // R1: one command action per byte boundary
  a_r1_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.welSet, ctl.welClr, ctl.fetchMem, ctl.fetchStat,
              ctl.memWrite, ctl.statWrite}));

endmodule

bind spi_nvmem_target spi_nvmem_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .csN   (csN),
  .soOe  (soOe),
  .ctl   (ctl),
  .welQ  (welQ),
  .addrQ (addrQ),
  .statQ (statQ)
);

// File: tb/spi_nvmem_target_bench.sv
module spi_nvmem_target_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic csA = 1'b1, csB = 1'b1;
  logic sck = 1'b0, si = 1'b0;
  wire  soA, soB;
  logic oeA, oeB;
  logic sel = 1'b0;
  logic mode3 = 1'b0;
  bit   done = 1'b0;

  spi_nvmem_target u_spi_nvmem_target (
    .clk(clk), .rstN(rstN), .csN(csA), .sck(sck), .si(si), .so(soA), .soOe(oeA)
  );

  spi_nvmem_target #(.ADDR_BYTES(1), .MEM_AW(9)) u_spi_nvmem_target_a8 (
    .clk(clk), .rstN(rstN), .csN(csB), .sck(sck), .si(si), .so(soB), .soOe(oeB)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] rxCap;
  event       rxEv;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the next expected byte whenever the driver completes a read byte
  always @(rxEv) begin
    if (expQ.size() == 0) begin
      chk(1'b0, "unexpected read byte", rxCap, 0);
    end else begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(rxCap == e, t, rxCap, e);
    end
  end

  task automatic waitT(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic curOe();
    return sel ? oeB : oeA;
  endfunction

  task automatic frameOpen();
    sck = mode3;
    waitT(4);
    if (sel) csB = 1'b0; else csA = 1'b0;
    waitT(8);
  endtask

  task automatic frameClose();
    if (!mode3) sck = 1'b0;
    waitT(8);
    csA = 1'b1;
    csB = 1'b1;
    waitT(16);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      si  = tx[i];
      waitT(8);
      rx[i] = sel ? soB : soA;
      sck = 1'b1;
      waitT(8);
    end
  endtask

  task automatic sendB(input logic [7:0] tx);
    logic [7:0] r;
    xfer(tx, r);
  endtask

  task automatic readExp(input logic [7:0] exp, input string tag);
    logic [7:0] r;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    xfer(8'h00, r);
    rxCap = r;
    -> rxEv;
  endtask

  task automatic cmd1(input logic [7:0] op);
    frameOpen(); sendB(op); frameClose();
  endtask

  task automatic rdStat(input logic [7:0] exp, input string tag);
    frameOpen(); sendB(8'h05); readExp(exp, tag); frameClose();
  endtask

  task automatic wrMem(input logic [15:0] a, input logic [7:0] d[$]);
    frameOpen();
    sendB(8'h02); sendB(a[15:8]); sendB(a[7:0]);
    foreach (d[k]) sendB(d[k]);
    frameClose();
  endtask

  task automatic rdMem(input logic [15:0] a, input logic [7:0] d[$], input string tag);
    frameOpen();
    sendB(8'h03); sendB(a[15:8]); sendB(a[7:0]);
    foreach (d[k]) readExp(d[k], tag);
    frameClose();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitT(5);
    rstN = 1'b1;
    waitT(5);

    // R11: reset state
    chk(oeA == 1'b0, "R11 output enable after reset", oeA, 0);
    rdStat(8'h00, "R11 status after reset");

    // R7: arm, status read does not disturb the latch
    cmd1(8'h06);
    rdStat(8'h02, "R7 latch set by arm");
    rdStat(8'h02, "R7 status read keeps latch");

    // R3: two-byte address, data right after it
    wrMem(16'h0123, '{8'hA5, 8'h5A, 8'h3C});
    rdStat(8'h00, "R7 latch cleared at end of write frame");
    rdMem(16'h0123, '{8'hA5, 8'h5A, 8'h3C}, "R3 sequential read mode 0");

    // R2: SCK idling high
    mode3 = 1'b1;
    rdMem(16'h0124, '{8'h5A, 8'h3C}, "R2 read in mode 3");
    mode3 = 1'b0;

    // R8: write without the latch has no effect
    wrMem(16'h0123, '{8'hFF});
    rdMem(16'h0123, '{8'hA5}, "R8 unarmed write ignored");

    // R5: pointer wraps at the top of the array
    cmd1(8'h06);
    wrMem(16'h07FE, '{8'h11, 8'h22, 8'h33});
    rdMem(16'h0000, '{8'h33}, "R5 write wrapped to zero");
    rdMem(16'h07FE, '{8'h11, 8'h22, 8'h33}, "R5 read wraps to zero");

    // R6: partial byte discarded, whole bytes committed
    cmd1(8'h06);
    wrMem(16'h0010, '{8'h66, 8'h44});
    cmd1(8'h06);
    frameOpen();
    sendB(8'h02); sendB(8'h00); sendB(8'h10); sendB(8'h77);
    for (int i = 7; i >= 4; i--) begin
      sck = 1'b0; si = 1'b1; waitT(8);
      sck = 1'b1; waitT(8);
    end
    frameClose();
    rdMem(16'h0010, '{8'h77, 8'h44}, "R6 partial byte leaves array intact");

    // R10: unknown command ignored
    frameOpen();
    sendB(8'h55); sendB(8'h00);
    chk(curOe() == 1'b0, "R10 output undriven after unknown command", curOe(), 0);
    frameClose();
    rdStat(8'h00, "R10 unknown command changes nothing");

    // R1: only the first byte is a command
    frameOpen();
    sendB(8'h06); sendB(8'h05); sendB(8'h00);
    chk(curOe() == 1'b0, "R1 second command byte not decoded", curOe(), 0);
    frameClose();
    rdStat(8'h02, "R1 first command byte acted");

    // R7: status write with latch set
    frameOpen(); sendB(8'h01); sendB(8'hFF); frameClose();
    rdStat(8'h8C, "R7 status write loads bits and drops latch");

    // R8: status write without latch
    frameOpen(); sendB(8'h01); sendB(8'h00); frameClose();
    rdStat(8'h8C, "R8 unarmed status write ignored");

    // R7: disarm
    cmd1(8'h06);
    cmd1(8'h04);
    rdStat(8'h8C, "R7 disarm clears latch");

    // R9: read cut off by chip select
    frameOpen();
    sendB(8'h03); sendB(8'h01); sendB(8'h23);
    sck = 1'b0;
    waitT(8);
    chk(oeA == 1'b1, "R9 driving during read", oeA, 1);
    csA = 1'b1;
    @(negedge clk);
    chk(oeA == 1'b0, "R9 stops at chip select rise", oeA, 0);
    waitT(16);

    // R4: one-byte address copy, bit 3 of command is address bit 8
    sel = 1'b1;
    cmd1(8'h06);
    frameOpen(); sendB(8'h02); sendB(8'h30); sendB(8'hC5); frameClose();
    cmd1(8'h06);
    frameOpen(); sendB(8'h0A); sendB(8'h30); sendB(8'h5C); frameClose();
    frameOpen(); sendB(8'h0B); sendB(8'h30); readExp(8'h5C, "R4 upper half via 0x0B"); frameClose();
    frameOpen(); sendB(8'h03); sendB(8'h30); readExp(8'hC5, "R4 lower half via 0x03"); frameClose();
    sel = 1'b0;

    waitT(4);
    chk(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule